// File: doc/BRIEF.md
# AHB-to-APB Bridge with Clock-Enabled Peripheral Side

This block sits on the fast system bus as an AHB slave and drives a small group of peripherals as an APB master. It takes one AHB transfer aimed at the peripheral region and registers its address and control. One cycle later it registers the write data. It then runs a single non-pipelined APB transfer: a setup phase with a select line up, followed by an access phase with the enable line up. The access phase lasts until the addressed peripheral reports ready. During the whole conversion the AHB master is stalled with wait states. At the end the bridge returns read data, or a two-cycle error response if the peripheral flagged a fault or the address decoded to no peripheral.

The peripheral side advances only in cycles where an internal strobe is high. The strobe fires once every `APB_DIV` AHB cycles and is also brought out as a port, so peripherals can share the same slow rate. Each APB phase therefore stretches over a whole number of AHB cycles. The default ratio is two, and a ratio of one gives full rate. The block suits slow, rarely accessed peripherals, where a handful of extra AHB cycles per access costs little.

Top module: `ahb2apb_ratebridge`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `ahb_ready_out` is 1, `ahb_err` is 0, `apb_sel` is all zero and `apb_enable` is 0.
- R2: With `ahb_sel` high, an address phase whose `ahb_trans` is IDLE (2'b00) or BUSY (2'b01) gets, in the next cycle, `ahb_ready_out`=1 and `ahb_err`=0, and no APB select goes high.
- R3: A transfer is accepted in a cycle where `ahb_sel`, `ahb_ready_in` and `ahb_trans[1]` are high (NONSEQ 2'b10 or SEQ 2'b11) while the bridge is free. Its address and `ahb_write` appear on `apb_addr` and `apb_write`. The `ahb_wdata` presented in the following cycle appears on `apb_wdata`. All three hold for as long as the select is high.
- R4: Let the address phase be cycle a. The select goes high in the cycle after the first strobe cycle at or after a+2. It then stays high with `apb_enable` low for exactly `APB_DIV` cycles, after which `apb_enable` rises.
- R5: `apb_enable` stays high until a strobe cycle in which `apb_ready` is high. Each extra strobe cycle with `apb_ready` low adds `APB_DIV` AHB cycles. `apb_ready` in cycles without the strobe has no effect.
- R6: `ahb_ready_out` is low from cycle a+1 up to the cycle before the response cycle. For a completed mapped transfer, the response cycle is the one right after the completing strobe cycle.
- R7: A read that completes without a peripheral error returns, in its response cycle, the `apb_rdata` sampled at completion on `ahb_rdata`, with `ahb_err`=0.
- R8: If `apb_err` is high with the completing `apb_ready`, the bridge gives a two-cycle error: `ahb_err`=1 with `ahb_ready_out`=0, then `ahb_err`=1 with `ahb_ready_out`=1.
- R9: An address whose slot number (R12) is `NUM_PERIPH` or above gets the two-cycle error in cycles a+2 and a+3, and no select goes high.
- R10: `apb_tick` is high in exactly one cycle of every `APB_DIV`, first in cycle `APB_DIV`-1 after reset falls. Select and enable change only in the cycle right after a strobe cycle.
- R11: Select and enable fall in the same cycle, the response cycle. A new transfer presented during that cycle is accepted with no idle cycle in between.
- R12: The slot number is `ahb_addr[ADDR_W-1:WIN_BITS]`. Slot k below `NUM_PERIPH` drives only `apb_sel[k]`, so the select is one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AHB clock; the APB side runs on it with a strobe |
| rst | input | 1 | Synchronous active-high reset |
| ahb_sel | input | 1 | Slave select from the AHB decoder |
| ahb_addr | input | ADDR_W | Transfer address |
| ahb_trans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| ahb_write | input | 1 | 1 for write, 0 for read |
| ahb_wdata | input | DATA_W | Write data, valid in the data phase |
| ahb_ready_in | input | 1 | Bus-wide ready from the previous transfer |
| ahb_ready_out | output | 1 | This slave's ready; low inserts wait states |
| ahb_err | output | 1 | Response: 0 OKAY, 1 ERROR |
| ahb_rdata | output | DATA_W | Read data |
| apb_tick | output | 1 | Peripheral-side clock-enable strobe |
| apb_sel | output | NUM_PERIPH | One-hot peripheral select |
| apb_enable | output | 1 | Access-phase marker |
| apb_addr | output | ADDR_W | Peripheral address |
| apb_write | output | 1 | Peripheral direction |
| apb_wdata | output | DATA_W | Peripheral write data |
| apb_rdata | input | DATA_W | Peripheral read data |
| apb_ready | input | 1 | Peripheral ready, sampled on strobe cycles |
| apb_err | input | 1 | Peripheral fault, sampled with the ready |

## Verification
The bench sweeps every slot, including one beyond the mapped range, against both directions, zero to two peripheral wait states and both peripheral response codes. Each transfer is started either back-to-back with the previous response or after an IDLE or BUSY cycle. The choice of start shifts the transfer against the strobe phase, which separates a setup phase that waits for the strobe from one that starts early. The wait-state count separates an access phase that honours `apb_ready` only on strobe cycles from one that reacts to it at once, because ready is already high in a non-strobe cycle when no waits are requested. The unmapped slot and the error flag tell the decode-miss timing apart from the peripheral-fault timing. Read-back data depends on the address, so a wrong slot or a stale address shows up in the returned value.

// File: rtl/rb_pkg.sv
package rb_pkg;

    // AHB transfer-type encodings
    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    // Conversion sequence states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // free, zero-wait OKAY
        ST_CAPT   = 3'd1,  // AHB data phase: write data captured
        ST_WSETUP = 3'd2,  // waiting for a strobe to open setup
        ST_SETUP  = 3'd3,  // select up, enable down
        ST_ACCESS = 3'd4,  // select and enable up
        ST_RESP   = 3'd5,  // OKAY response, free again
        ST_ERR1   = 3'd6,  // first error cycle, stalled
        ST_ERR2   = 3'd7   // second error cycle, free again
    } rb_state_e;

    // Control captured with the address
    typedef struct packed {
        logic wr;   // direction
        logic hit;  // address decoded to a peripheral
    } rb_attr_t;

    function automatic logic rb_is_real(input logic [1:0] tr);
        return tr[1];
    endfunction

    function automatic logic rb_side_free(input rb_state_e s);
        return (s == ST_IDLE) || (s == ST_RESP) || (s == ST_ERR2);
    endfunction

    function automatic logic rb_is_err(input rb_state_e s);
        return (s == ST_ERR1) || (s == ST_ERR2);
    endfunction

endpackage

// File: rtl/rb_tick_gen.sv
module rb_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = (cnt_q == LAST);

endmodule

// File: rtl/rb_slot_decode.sv
module rb_slot_decode #(
    parameter int ADDR_W   = 12,
    parameter int WIN_BITS = 8,
    parameter int NP       = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NP-1:0]     onehot,
    output logic              hit
);
    localparam int SW = ADDR_W - WIN_BITS;

    logic [SW-1:0] slot;
    assign slot = addr[ADDR_W-1:WIN_BITS];

    for (genvar i = 0; i < NP; i++) begin : g_slot
        assign onehot[i] = (slot == SW'(i));
    end

    assign hit = |onehot;

endmodule

// File: rtl/rb_seq_fsm.sv
module rb_seq_fsm
    import rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ahb_sel,
    input  logic [1:0] ahb_trans,
    input  logic       ahb_ready_in,
    input  logic       hit,
    input  logic       tick,
    input  logic       apb_ready,
    input  logic       apb_err,
    output logic       accept,
    output logic       data_phase,
    output logic       load_apb,
    output logic       finish,
    output logic       penable,
    output logic       ready_out,
    output logic       err_out
);
    rb_state_e state_q, state_d;
    logic      penable_q;

    assign accept = rb_side_free(state_q) & ahb_sel & ahb_ready_in
                  & rb_is_real(ahb_trans);

    always_comb begin
        state_d  = state_q;
        load_apb = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RESP, ST_ERR2: state_d = accept ? ST_CAPT : ST_IDLE;
            ST_CAPT:   state_d = hit ? ST_WSETUP : ST_ERR1;
            ST_WSETUP: if (tick) begin
                           load_apb = 1'b1;
                           state_d  = ST_SETUP;
                       end
            ST_SETUP:  if (tick) state_d = ST_ACCESS;
            ST_ACCESS: if (tick && apb_ready) begin
                           finish  = 1'b1;
                           state_d = apb_err ? ST_ERR1 : ST_RESP;
                       end
            ST_ERR1:   state_d = ST_ERR2;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            penable_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            penable_q <= (state_d == ST_ACCESS);
        end
    end

    assign data_phase = (state_q == ST_CAPT);
    assign penable    = penable_q;
    assign ready_out  = rb_side_free(state_q);
    assign err_out    = rb_is_err(state_q);

endmodule

// File: rtl/ahb2apb_ratebridge.sv
module ahb2apb_ratebridge
    import rb_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int NUM_PERIPH = 4,
    parameter int WIN_BITS   = 8,
    parameter int APB_DIV    = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ahb_sel,
    input  logic [ADDR_W-1:0]     ahb_addr,
    input  logic [1:0]            ahb_trans,
    input  logic                  ahb_write,
    input  logic [DATA_W-1:0]     ahb_wdata,
    input  logic                  ahb_ready_in,
    output logic                  ahb_ready_out,
    output logic                  ahb_err,
    output logic [DATA_W-1:0]     ahb_rdata,
    output logic                  apb_tick,
    output logic [NUM_PERIPH-1:0] apb_sel,
    output logic                  apb_enable,
    output logic [ADDR_W-1:0]     apb_addr,
    output logic                  apb_write,
    output logic [DATA_W-1:0]     apb_wdata,
    input  logic [DATA_W-1:0]     apb_rdata,
    input  logic                  apb_ready,
    input  logic                  apb_err
);
    // Decode and strobe
    logic [NUM_PERIPH-1:0] dec_onehot;
    logic                  dec_hit;
    logic                  tick;

    rb_tick_gen #(.DIV(APB_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    rb_slot_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .NP      (NUM_PERIPH)
    ) u_dec (
        .addr  (ahb_addr),
        .onehot(dec_onehot),
        .hit   (dec_hit)
    );

    // Captured request
    logic [ADDR_W-1:0]     addr_q;
    rb_attr_t              attr_q;
    logic [NUM_PERIPH-1:0] onehot_q;
    logic [DATA_W-1:0]     wdata_q;

    // Sequencer handshakes
    logic accept, data_phase, load_apb, finish;

    rb_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ahb_sel     (ahb_sel),
        .ahb_trans   (ahb_trans),
        .ahb_ready_in(ahb_ready_in),
        .hit         (attr_q.hit),
        .tick        (tick),
        .apb_ready   (apb_ready),
        .apb_err     (apb_err),
        .accept      (accept),
        .data_phase  (data_phase),
        .load_apb    (load_apb),
        .finish      (finish),
        .penable     (apb_enable),
        .ready_out   (ahb_ready_out),
        .err_out     (ahb_err)
    );

    // Address phase capture
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            attr_q   <= '0;
            onehot_q <= '0;
        end else if (accept) begin
            addr_q   <= ahb_addr;
            attr_q   <= '{wr: ahb_write, hit: dec_hit};
            onehot_q <= dec_onehot;
        end
    end

    // Data phase capture
    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
        end else if (data_phase) begin
            wdata_q <= ahb_wdata;
        end
    end

    // Peripheral-side registers, loaded only on strobe edges
    logic [NUM_PERIPH-1:0] sel_q;
    logic [ADDR_W-1:0]     paddr_q;
    logic                  pwrite_q;
    logic [DATA_W-1:0]     pwdata_q;
    logic [DATA_W-1:0]     rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= '0;
            paddr_q  <= '0;
            pwrite_q <= 1'b0;
            pwdata_q <= '0;
        end else if (load_apb) begin
            sel_q    <= onehot_q;
            paddr_q  <= addr_q;
            pwrite_q <= attr_q.wr;
            pwdata_q <= wdata_q;
        end else if (finish) begin
            sel_q    <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (finish && !attr_q.wr) begin
            rdata_q <= apb_rdata;
        end
    end

    assign apb_tick  = tick;
    assign apb_sel   = sel_q;
    assign apb_addr  = paddr_q;
    assign apb_write = pwrite_q;
    assign apb_wdata = pwdata_q;
    assign ahb_rdata = rdata_q;

endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] apb_sel,
    input logic          apb_enable,
    input logic          apb_ready,
    input logic          apb_tick,
    input logic          ahb_ready_out,
    input logic          ahb_err
);
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(apb_sel)); // R12

    AST_ENABLE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        apb_enable |-> (|apb_sel)); // R4

    AST_ENABLE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(apb_enable) |-> ($past(|apb_sel) && !$past(apb_enable))); // R4

    AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$stable(apb_sel) || !$stable(apb_enable)) |-> $past(apb_tick)); // R10

    AST_ACCESS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (apb_enable && !(apb_tick && apb_ready)) |=> apb_enable); // R5

    AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $fell(apb_enable) |-> (apb_sel == '0)); // R11

    AST_STALL_DURING_APB: assert property (@(posedge clk) disable iff (rst)
        (|apb_sel) |-> !ahb_ready_out); // R6

    AST_ERROR_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (ahb_err && !ahb_ready_out) |=> (ahb_err && ahb_ready_out)); // R8

endmodule

bind ahb2apb_ratebridge rb_checker #(.NP(NUM_PERIPH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .apb_sel      (apb_sel),
    .apb_enable   (apb_enable),
    .apb_ready    (apb_ready),
    .apb_tick     (apb_tick),
    .ahb_ready_out(ahb_ready_out),
    .ahb_err      (ahb_err)
);

// File: tb/ahb2apb_ratebridge_tb.sv
`timescale 1ns/1ps
module ahb2apb_ratebridge_tb_top;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int NP  = 4;
    localparam int WIN = 8;
    localparam int DIV = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ahb_sel;
    logic [AW-1:0] ahb_addr;
    logic [1:0]    ahb_trans;
    logic          ahb_write;
    logic [DW-1:0] ahb_wdata;
    logic          ahb_ready_out;
    logic          ahb_err;
    logic [DW-1:0] ahb_rdata;
    logic          apb_tick;
    logic [NP-1:0] apb_sel;
    logic          apb_enable;
    logic [AW-1:0] apb_addr;
    logic          apb_write;
    logic [DW-1:0] apb_wdata;
    logic [DW-1:0] apb_rdata;
    logic          apb_ready;
    logic          apb_err;

    always #4 clk = ~clk;  // 125 MHz

    // Peripheral read data depends on the address it sees
    assign apb_rdata = 32'h5A00_0000 ^ DW'(apb_addr);

    ahb2apb_ratebridge #(
        .ADDR_W(AW), .DATA_W(DW), .NUM_PERIPH(NP), .WIN_BITS(WIN), .APB_DIV(DIV)
    ) dut_i (
        .clk(clk), .rst(rst),
        .ahb_sel(ahb_sel), .ahb_addr(ahb_addr), .ahb_trans(ahb_trans),
        .ahb_write(ahb_write), .ahb_wdata(ahb_wdata),
        .ahb_ready_in(ahb_ready_out),
        .ahb_ready_out(ahb_ready_out), .ahb_err(ahb_err), .ahb_rdata(ahb_rdata),
        .apb_tick(apb_tick), .apb_sel(apb_sel), .apb_enable(apb_enable),
        .apb_addr(apb_addr), .apb_write(apb_write), .apb_wdata(apb_wdata),
        .apb_rdata(apb_rdata), .apb_ready(apb_ready), .apb_err(apb_err)
    );

    int cyc;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic bit tick_exp(input int c);
        return (c % DIV) == (DIV - 1);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One address phase of IDLE or BUSY, response checked next cycle
    task automatic idle_cycle(input logic [1:0] tr);
        ahb_sel   = 1'b1;
        ahb_trans = tr;
        @(negedge clk);
        chk("R2", "ready after idle/busy", 64'(ahb_ready_out), 64'd1);
        chk("R2", "okay after idle/busy", 64'(ahb_err), 64'd0);
        chk("R2", "no select after idle/busy", 64'(apb_sel), 64'd0);
        chk("R10", "strobe phase", 64'(apb_tick), 64'(tick_exp(cyc)));
    endtask

    // Full transfer; starts and ends at a negedge where ready is high
    task automatic run_xfer(input int slot, input int offs, input bit wr,
                            input int w, input bit serr, input bit seq,
                            input logic [DW-1:0] wd);
        logic [AW-1:0] addr;
        bit mapped;
        int a, t1, t3, comp, errc, acc;
        bit done;
        addr   = AW'((slot << WIN) | offs);
        mapped = (slot < NP);
        a      = cyc;
        t1     = a + 2;
        while (!tick_exp(t1)) t1++;
        t3 = t1 + DIV * (2 + w);
        if (!mapped) begin
            errc = a + 2; comp = a + 3;
        end else if (serr) begin
            errc = t3 + 1; comp = t3 + 2;
        end else begin
            errc = -1; comp = t3 + 1;
        end
        acc  = 0;
        done = 1'b0;
        ahb_sel   = 1'b1;
        ahb_trans = seq ? 2'b11 : 2'b10;
        ahb_addr  = addr;
        ahb_write = wr;
        @(negedge clk);
        ahb_sel   = 1'b0;
        ahb_trans = 2'b00;
        ahb_wdata = wd;
        while (!done) begin
            int c;
            bit exp_sel, exp_en;
            c       = cyc;
            exp_sel = mapped && (c >= t1 + 1) && (c <= t3);
            exp_en  = mapped && (c >= t1 + DIV + 1) && (c <= t3);
            apb_ready = apb_enable && (acc == w);
            apb_err   = serr;
            chk("R10", "strobe phase", 64'(apb_tick), 64'(tick_exp(c)));
            chk("R4 R12 R9 R11", "select", 64'(apb_sel),
                exp_sel ? 64'(1 << slot) : 64'd0);
            chk("R4 R5 R11", "enable", 64'(apb_enable), 64'(exp_en));
            if (exp_sel) begin
                chk("R3", "apb address", 64'(apb_addr), 64'(addr));
                chk("R3", "apb direction", 64'(apb_write), 64'(wr));
                if (wr) chk("R3", "apb write data", 64'(apb_wdata), 64'(wd));
            end
            chk("R6", "ahb ready", 64'(ahb_ready_out), 64'(c == comp));
            chk("R8 R9", "ahb error", 64'(ahb_err),
                64'((c == errc) || (errc >= 0 && c == comp)));
            if (c == comp) begin
                if (mapped && !serr && !wr)
                    chk("R7", "read data", 64'(ahb_rdata),
                        64'(32'h5A00_0000 ^ DW'(addr)));
                done = 1'b1;
            end else begin
                if (tick_exp(c) && apb_enable) acc++;
                if (c > a + 200) begin
                    chk("R6", "transfer never completed", 64'(c), 64'(comp));
                    done = 1'b1;
                end else begin
                    @(negedge clk);
                end
            end
        end
        apb_ready = 1'b0;
    endtask

    initial begin
        int n;
        ahb_sel   = 1'b0;
        ahb_addr  = '0;
        ahb_trans = 2'b00;
        ahb_write = 1'b0;
        ahb_wdata = '0;
        apb_ready = 1'b0;
        apb_err   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", 64'(ahb_ready_out), 64'd1);
        chk("R1", "error in reset", 64'(ahb_err), 64'd0);
        chk("R1", "select in reset", 64'(apb_sel), 64'd0);
        chk("R1", "enable in reset", 64'(apb_enable), 64'd0);
        rst = 1'b0;
        #1;
        chk("R1", "ready after reset", 64'(ahb_ready_out), 64'd1);
        chk("R1", "select after reset", 64'(apb_sel), 64'd0);
        chk("R10", "strobe phase at start", 64'(apb_tick), 64'(tick_exp(0)));

        n = 0;
        for (int slot = 0; slot <= NP; slot++) begin
            for (int wr = 0; wr < 2; wr++) begin
                for (int w = 0; w < 3; w++) begin
                    for (int serr = 0; serr < 2; serr++) begin
                        for (int gap = 0; gap < 2; gap++) begin
                            if (slot == NP && (w > 0 || serr != 0)) continue;
                            if (gap != 0) idle_cycle((n % 2) != 0 ? 2'b01 : 2'b00);
                            run_xfer(slot, (n * 4) & 8'hFC, wr[0], w, serr[0],
                                     (n % 3) == 1, 32'hC0DE_0000 + 32'(n * 37));
                            n++;
                        end
                    end
                end
            end
        end
        idle_cycle(2'b00);
        idle_cycle(2'b01);
        summary();
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule